// File: doc/BRIEF.md
# Region-of-Interest Contrast Attenuator

This block sits in a video path that carries one 8-bit sample per valid cycle, along with markers for the first sample of a line and the first sample of a field. The host sets a rectangle in column/line coordinates and a background gain. Samples inside the rectangle leave the block unchanged. Samples outside it are pulled towards mid-grey by the gain, so a cheaper background can be coded later in the chain while the area of interest keeps its full detail.

The host writes settings through a small write-only register port into a shadow copy. The shadow is loaded into the working copy on the first sample of each field. A whole field therefore always sees one consistent setting. The rectangle and the gain may be changed every field, so the box can creep across the picture one step per field or jump to a new place in one field.

Top module: `roi_contrast`

## Requirements
- R1: After reset all outputs are 0, and the working setting is a box covering every position with gain 255, so the first field passes through unchanged.
- R2: A valid sample whose position lies inside the box appears unchanged on `pix_o` one cycle later.
- R3: A valid sample outside the box leaves as 128 + q, where s = sample − 128 and q = floor((s·g·257 + 32768) / 65536), limited to −128..127. g is the gain in force. Gain 0 therefore yields 128.
- R4: With gain 255 a sample outside the box also leaves unchanged.
- R5: Register writes land in a shadow copy. Address 0 is the first column, 1 the last column, 2 the first line, 3 the last line, and 4 the gain; values are taken from the low bits of the data. The shadow takes effect from the valid sample that carries the field marker, including that sample, and a write made in the middle of a field does not alter the rest of that field.
- R6: Position counting works as follows. A valid sample with the field marker is column 0, line 0; the field marker wins over a line marker on the same sample. A valid sample with only the line marker is column 0 of the next line. Every other valid sample is one column right of the previous one. Cycles without valid do not advance the position.
- R7: Box bounds are inclusive. If the first column is greater than the last column, or the first line is greater than the last line, no sample is inside the box.
- R8: `pix_valid_o` repeats `pix_valid_i` one cycle later. `line_start_o` and `field_start_o` repeat their markers one cycle later, qualified by valid.
- R9: Writes to addresses 5, 6 and 7 change no setting.
- R10: Positions reach at least column 719 and line 287, and a box placed at that corner is classified correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid_i | input | 1 | Input sample valid |
| line_start_i | input | 1 | First sample of a line |
| field_start_i | input | 1 | First sample of a field |
| pix_i | input | 8 | Input sample |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 10 | Register write data |
| pix_valid_o | output | 1 | Output sample valid |
| line_start_o | output | 1 | Delayed line marker |
| field_start_o | output | 1 | Delayed field marker |
| pix_o | output | 8 | Output sample |

## Verification
Every result of this block appears exactly one clock after the input sample that caused it: the data, the valid flag and both markers pass through a single register stage. The bench drives each sample on a falling edge and checks the outputs one nanosecond after the next rising edge, which is the cycle that register stage loads. Setting changes are checked at field granularity. A mid-field write must leave the remaining samples of that field on the old setting, and the next field-marked sample must show the new one.

// File: rtl/roi_pkg.sv
package roi_pkg;
    localparam int PIX_W  = 8;
    localparam int COL_W  = 10;
    localparam int ROW_W  = 9;
    localparam int GAIN_W = 8;
    localparam int CFG_AW = 3;
    localparam int CFG_DW = (COL_W > ROW_W) ? COL_W : ROW_W;

    typedef struct packed {
        logic [COL_W-1:0]  col_lo;
        logic [COL_W-1:0]  col_hi;
        logic [ROW_W-1:0]  row_lo;
        logic [ROW_W-1:0]  row_hi;
        logic [GAIN_W-1:0] gain;
    } roi_cfg_t;

    typedef enum logic [CFG_AW-1:0] {
        REG_COL_LO = 3'd0,
        REG_COL_HI = 3'd1,
        REG_ROW_LO = 3'd2,
        REG_ROW_HI = 3'd3,
        REG_GAIN   = 3'd4
    } roi_reg_e;

    localparam roi_cfg_t CFG_RESET = '{col_lo: '0, col_hi: '1,
                                       row_lo: '0, row_hi: '1, gain: '1};
endpackage

// File: rtl/roi_raster_pos.sv
module roi_raster_pos
    import roi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             line_go,
    input  logic             field_go,
    output logic [COL_W-1:0] col_cur,
    output logic [ROW_W-1:0] row_cur
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (field_go) begin
            col_cur = '0;
            row_cur = '0;
        end else if (line_go) begin
            col_cur = '0;
            row_cur = pos_q.row + 1'b1;
        end else begin
            col_cur = pos_q.col;
            row_cur = pos_q.row;
        end
        if (valid) begin
            pos_d.col = col_cur + 1'b1;
            pos_d.row = row_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/roi_cfg_regs.sv
module roi_cfg_regs
    import roi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [CFG_DW-1:0] wr_data,
    input  logic              field_go,
    output roi_cfg_t          act_cur,
    output roi_cfg_t          act_held
);
    typedef struct packed {
        roi_cfg_t shadow;
        roi_cfg_t active;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (field_go) st_d.active = st_q.shadow;
        if (wr_en) begin
            case (roi_reg_e'(wr_addr))
                REG_COL_LO: st_d.shadow.col_lo = wr_data[COL_W-1:0];
                REG_COL_HI: st_d.shadow.col_hi = wr_data[COL_W-1:0];
                REG_ROW_LO: st_d.shadow.row_lo = wr_data[ROW_W-1:0];
                REG_ROW_HI: st_d.shadow.row_hi = wr_data[ROW_W-1:0];
                REG_GAIN:   st_d.shadow.gain   = wr_data[GAIN_W-1:0];
                default: ;
            endcase
        end
        act_cur  = field_go ? st_q.shadow : st_q.active;
        act_held = st_q.active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shadow <= CFG_RESET;
            st_q.active <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/roi_bg_scale.sv
module roi_bg_scale #(
    parameter int DATA_W = 8,
    parameter int G_W    = 8
) (
    input  logic [DATA_W-1:0] pix,
    input  logic [G_W-1:0]    gain,
    output logic [DATA_W-1:0] scaled
);
    localparam int TW = DATA_W + 2 * G_W + 4;
    localparam logic signed [TW-1:0] MULT = TW'((1 << G_W) + 1);
    localparam logic signed [TW-1:0] HALF = TW'(1 << (2 * G_W - 1));
    localparam logic signed [TW-1:0] MAXV = TW'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [TW-1:0] MINV = -TW'(1 << (DATA_W - 1));

    logic signed [DATA_W-1:0] centered;
    logic signed [TW-1:0]     c_ext, g_ext, acc, quo;
    logic        [DATA_W-1:0] q_lim;

    always_comb begin
        centered = $signed({~pix[DATA_W-1], pix[DATA_W-2:0]});
        c_ext    = TW'(centered);
        g_ext    = $signed(TW'(gain));
        acc      = c_ext * g_ext * MULT + HALF;
        quo      = acc >>> (2 * G_W);
        if (quo > MAXV)      q_lim = {1'b0, {(DATA_W-1){1'b1}}};
        else if (quo < MINV) q_lim = {1'b1, {(DATA_W-1){1'b0}}};
        else                 q_lim = quo[DATA_W-1:0];
        scaled = {~q_lim[DATA_W-1], q_lim[DATA_W-2:0]};
    end
endmodule

// File: rtl/roi_contrast.sv
module roi_contrast
    import roi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid_i,
    input  logic              line_start_i,
    input  logic              field_start_i,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    output logic              pix_valid_o,
    output logic              line_start_o,
    output logic              field_start_o,
    output logic [PIX_W-1:0]  pix_o
);
    typedef struct packed {
        logic             valid;
        logic             ls;
        logic             fs;
        logic [PIX_W-1:0] pix;
    } out_t;

    logic             field_go, line_go;
    logic [COL_W-1:0] col_cur;
    logic [ROW_W-1:0] row_cur;
    roi_cfg_t         act_cur, act_held;
    logic             in_box;
    logic [PIX_W-1:0] bg_pix;
    out_t             out_d, out_q;

    assign field_go = pix_valid_i & field_start_i;
    assign line_go  = pix_valid_i & line_start_i;

    roi_raster_pos i_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (pix_valid_i),
        .line_go  (line_go),
        .field_go (field_go),
        .col_cur  (col_cur),
        .row_cur  (row_cur)
    );

    roi_cfg_regs i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we_i),
        .wr_addr  (cfg_addr_i),
        .wr_data  (cfg_wdata_i),
        .field_go (field_go),
        .act_cur  (act_cur),
        .act_held (act_held)
    );

    roi_bg_scale #(.DATA_W(PIX_W), .G_W(GAIN_W)) i_scale (
        .pix    (pix_i),
        .gain   (act_cur.gain),
        .scaled (bg_pix)
    );

    always_comb begin
        in_box = (col_cur >= act_cur.col_lo) && (col_cur <= act_cur.col_hi) &&
                 (row_cur >= act_cur.row_lo) && (row_cur <= act_cur.row_hi);
        out_d.valid = pix_valid_i;
        out_d.ls    = line_go;
        out_d.fs    = field_go;
        out_d.pix   = in_box ? pix_i : bg_pix;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pix_valid_o   = out_q.valid;
    assign line_start_o  = out_q.ls;
    assign field_start_o = out_q.fs;
    assign pix_o         = out_q.pix;
endmodule

// File: rtl/roi_contrast_chk.sv
module roi_contrast_chk
    import roi_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid_i,
    input logic             line_start_i,
    input logic             field_start_i,
    input logic [PIX_W-1:0] pix_i,
    input logic             pix_valid_o,
    input logic             line_start_o,
    input logic             field_start_o,
    input logic [PIX_W-1:0] pix_o,
    input logic             in_box,
    input roi_cfg_t         act_cur,
    input roi_cfg_t         act_held
);
    localparam logic [PIX_W-1:0] MID = {1'b1, {(PIX_W-1){1'b0}}};

    AST_INSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && in_box) |=> (pix_o == $past(pix_i))); // R2

    AST_ZERO_GAIN_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && !in_box && act_cur.gain == '0) |=> (pix_o == MID)); // R3

    AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && act_cur.gain == '1) |=> (pix_o == $past(pix_i))); // R4

    AST_HOLD_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid_i && field_start_i) |=> $stable(act_held)); // R5

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o); // R8

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !(pix_valid_o || line_start_o || field_start_o)); // R8

    AST_FS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && field_start_i) |=> field_start_o); // R8

    AST_LS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && line_start_i) |=> line_start_o); // R8
endmodule

bind roi_contrast roi_contrast_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pix_valid_i   (pix_valid_i),
    .line_start_i  (line_start_i),
    .field_start_i (field_start_i),
    .pix_i         (pix_i),
    .pix_valid_o   (pix_valid_o),
    .line_start_o  (line_start_o),
    .field_start_o (field_start_o),
    .pix_o         (pix_o),
    .in_box        (in_box),
    .act_cur       (act_cur),
    .act_held      (act_held)
);

// File: tb/test_roi_contrast.sv
module test_roi_contrast;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid_i = 1'b0, line_start_i = 1'b0, field_start_i = 1'b0;
    logic [7:0] pix_i = '0;
    logic       cfg_we_i = 1'b0;
    logic [2:0] cfg_addr_i = '0;
    logic [9:0] cfg_wdata_i = '0;
    logic       pix_valid_o, line_start_o, field_start_o;
    logic [7:0] pix_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    roi_contrast i_roi_contrast (
        .clk(clk), .rst_n(rst_n),
        .pix_valid_i(pix_valid_i), .line_start_i(line_start_i),
        .field_start_i(field_start_i), .pix_i(pix_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .pix_valid_o(pix_valid_o), .line_start_o(line_start_o),
        .field_start_o(field_start_o), .pix_o(pix_o)
    );

    function automatic int exp_bg(int p, int g);
        int s = p - 128;
        int q = (s * g * 257 + 32768) >>> 16;
        if (q > 127)  q = 127;
        if (q < -128) q = -128;
        return q + 128;
    endfunction

    task automatic check(string tag, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got 0x%0h exp 0x%0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(int addr, int data);
        @(negedge clk);
        pix_valid_i = 1'b0; line_start_i = 1'b0; field_start_i = 1'b0;
        cfg_we_i = 1'b1; cfg_addr_i = 3'(addr); cfg_wdata_i = 10'(data);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic set_box(int cl, int ch, int rl, int rh, int g);
        cfg_write(0, cl); cfg_write(1, ch); cfg_write(2, rl);
        cfg_write(3, rh); cfg_write(4, g);
    endtask

    // drives lines r_from..r_to, ncols each; expects box/gain given; gap inserts idle cycles
    task automatic run_rows(int r_from, int r_to, int ncols,
                            int cl, int ch, int rl, int rh, int g,
                            int seed, bit gap, string tag);
        for (int r = r_from; r <= r_to; r++) begin
            for (int c = 0; c < ncols; c++) begin
                int p    = (r * 37 + c * 11 + seed) & 255;
                bit fs   = (r == 0) && (c == 0);
                bit ls   = (c == 0);
                bit insd = (c >= cl) && (c <= ch) && (r >= rl) && (r <= rh);
                int e    = insd ? p : exp_bg(p, g);
                @(negedge clk);
                pix_valid_i = 1'b1; line_start_i = ls; field_start_i = fs;
                pix_i = 8'(p);
                @(posedge clk); #1;
                check($sformatf("%s R8 r%0d c%0d", tag, r, c),
                      {pix_valid_o, field_start_o, line_start_o, pix_o},
                      {1'b1, fs, ls, 8'(e)});
                if (gap) begin
                    @(negedge clk);
                    pix_valid_i = 1'b0; line_start_i = 1'b1; field_start_i = 1'b0;
                    pix_i = 8'hA5;
                    @(posedge clk); #1;
                    check($sformatf("R6 idle r%0d c%0d", r, c),
                          {pix_valid_o, field_start_o, line_start_o}, 3'b000);
                end
            end
        end
        @(negedge clk);
        pix_valid_i = 1'b0; line_start_i = 1'b0; field_start_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset outputs", {pix_valid_o, line_start_o, field_start_o, pix_o}, 0);
        run_rows(0, 2, 4, 0, 1023, 0, 511, 255, 3, 1'b0, "R1 default");
    endtask

    task automatic t_box();
        set_box(2, 5, 1, 3, 64);
        run_rows(0, 5, 8, 2, 5, 1, 3, 64, 7, 1'b0, "R2 R3 R7 box");
    endtask

    task automatic t_gain_extremes();
        set_box(1, 2, 1, 2, 0);
        run_rows(0, 3, 4, 1, 2, 1, 2, 0, 9, 1'b0, "R3 gain0");
        cfg_write(4, 255);
        run_rows(0, 3, 4, 1, 2, 1, 2, 255, 21, 1'b0, "R4 gain255");
        cfg_write(4, 200);
        run_rows(0, 2, 4, 1, 2, 1, 2, 200, 40, 1'b0, "R3 gain200");
    endtask

    task automatic t_empty();
        set_box(5, 2, 0, 3, 100);
        run_rows(0, 3, 6, 5, 2, 0, 3, 100, 13, 1'b0, "R7 empty cols");
        set_box(0, 5, 3, 1, 150);
        run_rows(0, 3, 6, 0, 5, 3, 1, 150, 17, 1'b0, "R7 empty rows");
    endtask

    task automatic t_midfield();
        set_box(0, 1, 0, 1, 50);
        run_rows(0, 1, 5, 0, 1, 0, 1, 50, 5, 1'b0, "R5 before");
        set_box(3, 4, 2, 3, 200);
        run_rows(2, 4, 5, 0, 1, 0, 1, 50, 5, 1'b0, "R5 held");
        run_rows(0, 4, 5, 3, 4, 2, 3, 200, 29, 1'b0, "R5 next field");
    endtask

    task automatic t_gaps();
        set_box(1, 2, 0, 1, 30);
        run_rows(0, 2, 4, 1, 2, 0, 1, 30, 51, 1'b1, "R6 gaps");
    endtask

    task automatic t_bad_addr();
        set_box(1, 3, 1, 2, 80);
        cfg_write(5, 0); cfg_write(6, 0); cfg_write(7, 0);
        run_rows(0, 3, 5, 1, 3, 1, 2, 80, 61, 1'b0, "R9 bad addr");
    endtask

    task automatic t_corner();
        set_box(719, 719, 287, 287, 0);
        run_rows(0, 286, 1, 719, 719, 287, 287, 0, 77, 1'b0, "R10 col0");
        run_rows(287, 287, 720, 719, 719, 287, 287, 0, 77, 1'b0, "R10 last line");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_box();
        t_gain_extremes();
        t_empty();
        t_midfield();
        t_gaps();
        t_bad_addr();
        t_corner();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule